// File: doc/BRIEF.md
# Divider Configuration Port with Parallel and Serial Load

This block stores the settings of a frequency synthesizer's dividers: a 7-bit feedback divider value, a 2-bit post-divider code and a 3-bit diagnostic select code. The settings can come from two places. The first is a bank of parallel pins, used at power-up. The second is a three-wire serial port, used later to retune the output.

Serial data enters a 12-bit shift register. It moves one place for each rising edge of the serial clock. A serial load strobe copies the register into the settings while it is high and keeps the last copied value when it falls. A parallel load strobe passes the pins through while it is low and holds them from its rising edge. While that strobe is low the parallel path wins, and the diagnostic select is forced to zero.

The block runs entirely on one fast system clock. The strobes and the serial clock are sampled as levels, so the transparent latches become clock-enabled registers with one cycle of delay.

Top module: `divcfg_port`

## Requirements
- R1: After reset, the feedback value reads 127, the post-divider code reads 3, the diagnostic select reads 0 and the serial output reads 0. The block leaves reset on the third rising clock edge after rst_n goes high.
- R2: The shift register moves exactly one place for each low-to-high change of ser_clk seen on clk, taking in ser_din. Holding ser_clk high or low moves nothing. ser_out is the most significant bit of the register, which is the bit taken in 12 serial edges earlier.
- R3: Bits 11 to 9 of the serial word (the first three bits sent) form the diagnostic select, bits 8 and 7 form the post-divider code, and bits 6 to 0 form the feedback value. Each field is sent most significant bit first.
- R4: While par_ld is high and ser_ld is high, all three settings take the shift register's value one clock later, including while it is still shifting.
- R5: While par_ld is high and ser_ld is low, the settings keep their value. After ser_ld falls they keep what was copied on the last cycle it was high, and serial shifting has no effect on them.
- R6: While par_ld is low, the feedback value and post-divider code take par_m and par_n one clock later, and the diagnostic select is forced to 0.
- R7: When par_ld rises, the last pin values passed through are kept, and later changes on par_m and par_n have no effect.
- R8: While par_ld is low, ser_ld has no effect: the parallel path has priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all other inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial shift clock, sampled as a level |
| ser_din | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial load strobe; transparent while high |
| par_ld | input | 1 | Parallel load strobe; transparent while low, priority over serial |
| par_m | input | 7 | Parallel feedback divider value |
| par_n | input | 2 | Parallel post-divider code |
| m_val | output | 7 | Current feedback divider value |
| n_code | output | 2 | Current post-divider code |
| t_sel | output | 3 | Current diagnostic select code |
| ser_out | output | 1 | Most significant bit of the shift register |

## Verification
The bench holds ser_clk high for several system clocks to catch a design that shifts on a level rather than an edge; such a design would corrupt the word. It sends full words with ser_ld low and checks that the settings do not move until the strobe is pulsed. A design that packs the fields in the wrong order would show swapped select and divider values. With par_ld low it raises ser_ld, so a design with the wrong priority would show the serial word, or a diagnostic select other than zero. After par_ld rises it changes the pins, so a design that keeps passing them through would follow them.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  parameter int unsigned FB_W = 7;
  parameter int unsigned PD_W = 2;
  parameter int unsigned TS_W = 3;
  localparam int unsigned WORD_W = TS_W + PD_W + FB_W;

  // field order matches the serial stream: select first, feedback last
  typedef struct packed {
    logic [TS_W-1:0] tsel;
    logic [PD_W-1:0] pdiv;
    logic [FB_W-1:0] fb;
  } cfg_t;

  localparam cfg_t CFG_RST = '{tsel: '0, pdiv: '1, fb: '1};
endpackage

// File: rtl/divcfg_rstsync.sv
module divcfg_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_q = pipe_q[STAGES-1];
endmodule

// File: rtl/divcfg_edge.sv
module divcfg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/divcfg_shifter.sv
module divcfg_shifter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= sr_d;
  end

  assign word = sr_q;
endmodule

// File: rtl/divcfg_regs.sv
module divcfg_regs
  import divcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_ld,
  input  logic              ser_ld,
  input  logic [FB_W-1:0]   par_m,
  input  logic [PD_W-1:0]   par_n,
  input  logic [WORD_W-1:0] word,
  output cfg_t              cfg
);
  cfg_t cfg_q;
  cfg_t cfg_d;
  logic load_en;

  // parallel path first: while its strobe is low, the serial path is ignored
  always_comb begin
    cfg_d   = cfg_q;
    load_en = 1'b0;
    if (!par_ld) begin
      load_en    = 1'b1;
      cfg_d.fb   = par_m;
      cfg_d.pdiv = par_n;
      cfg_d.tsel = '0;
    end else if (ser_ld) begin
      load_en = 1'b1;
      cfg_d   = cfg_t'(word);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= CFG_RST;
    else if (load_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/divcfg_port.sv
module divcfg_port
  import divcfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_clk,
  input  logic            ser_din,
  input  logic            ser_ld,
  input  logic            par_ld,
  input  logic [FB_W-1:0] par_m,
  input  logic [PD_W-1:0] par_n,
  output logic [FB_W-1:0] m_val,
  output logic [PD_W-1:0] n_code,
  output logic [TS_W-1:0] t_sel,
  output logic            ser_out
);
  logic              rst_q;
  logic              sclk_rise;
  logic [WORD_W-1:0] sr_word;
  cfg_t              cfg;

  divcfg_rstsync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  divcfg_edge u_sclk (
    .clk   (clk),
    .rst_n (rst_q),
    .lvl   (ser_clk),
    .rise  (sclk_rise)
  );

  divcfg_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_q),
    .shift_en (sclk_rise),
    .din      (ser_din),
    .word     (sr_word)
  );

  divcfg_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_q),
    .par_ld (par_ld),
    .ser_ld (ser_ld),
    .par_m  (par_m),
    .par_n  (par_n),
    .word   (sr_word),
    .cfg    (cfg)
  );

  assign m_val   = cfg.fb;
  assign n_code  = cfg.pdiv;
  assign t_sel   = cfg.tsel;
  assign ser_out = sr_word[WORD_W-1];
endmodule

// File: rtl/divcfg_chk.sv
module divcfg_chk
  import divcfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ser_clk,
  input logic              ser_din,
  input logic              ser_ld,
  input logic              par_ld,
  input logic [FB_W-1:0]   par_m,
  input logic [PD_W-1:0]   par_n,
  input logic [WORD_W-1:0] sr,
  input logic [FB_W-1:0]   m_val,
  input logic [PD_W-1:0]   n_code,
  input logic [TS_W-1:0]   t_sel
);
  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && !$past(ser_clk)) |=> sr == {$past(sr[WORD_W-2:0]), $past(ser_din)});

  // R2
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_clk && !$past(ser_clk)) |=> $stable(sr));

  // R6
  par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_ld |=> (m_val == $past(par_m) && n_code == $past(par_n) && t_sel == '0));

  // R4
  ser_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_ld && ser_ld) |=> {t_sel, n_code, m_val} == $past(sr));

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_ld && !ser_ld) |=> $stable({t_sel, n_code, m_val}));
endmodule

bind divcfg_port divcfg_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_q),
  .ser_clk (ser_clk),
  .ser_din (ser_din),
  .ser_ld  (ser_ld),
  .par_ld  (par_ld),
  .par_m   (par_m),
  .par_n   (par_n),
  .sr      (sr_word),
  .m_val   (m_val),
  .n_code  (n_code),
  .t_sel   (t_sel)
);

// File: tb/divcfg_port_bench.sv
`timescale 1ns/1ps
module divcfg_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_clk, ser_din, ser_ld, par_ld;
  logic [6:0] par_m;
  logic [1:0] par_n;
  logic [6:0] m_val;
  logic [1:0] n_code;
  logic [2:0] t_sel;
  logic       ser_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  divcfg_port u_divcfg_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_ld(ser_ld), .par_ld(par_ld), .par_m(par_m), .par_n(par_n),
    .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .ser_out(ser_out)
  );

  // behavioural reference model
  bit   mq[$];
  int   em, en, et;
  bit   prev_sc;
  int   rcnt;
  bit   live;

  function automatic int packed_sr();
    int v = 0;
    foreach (mq[i]) v = (v << 1) | int'(mq[i]);
    return v;
  endfunction

  task automatic model_reset();
    mq.delete();
    for (int i = 0; i < 12; i++) mq.push_back(1'b0);
    em = 127; en = 3; et = 0; prev_sc = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; live = 1'b0; model_reset();
    end else if (rcnt < 2) begin
      rcnt++; model_reset();
    end else begin
      int w;
      live = 1'b1;
      w = packed_sr();
      if (!par_ld) begin
        em = int'(par_m); en = int'(par_n); et = 0;
      end else if (ser_ld) begin
        et = (w >> 9) & 7; en = (w >> 7) & 3; em = w & 127;
      end
      if (ser_clk && !prev_sc) begin
        mq.push_back(ser_din);
        void'(mq.pop_front());
      end
      prev_sc = ser_clk;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !done) begin
      chk("R4 R5 R6 cycle m", int'(m_val), em);
      chk("R4 R5 R6 cycle n", int'(n_code), en);
      chk("R4 R5 R6 cycle t", int'(t_sel), et);
      chk("R2 cycle ser_out", int'(ser_out), (packed_sr() >> 11) & 1);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(bit b);
    ser_din = b; ser_clk = 1'b1; tick(2);
    ser_clk = 1'b0; tick(2);
  endtask

  task automatic sword(logic [11:0] w);
    for (int i = 11; i >= 0; i--) sbit(w[i]);
  endtask

  task automatic spulse();
    ser_ld = 1'b1; tick(2); ser_ld = 1'b0; tick(1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_din = 1'b0; ser_ld = 1'b0;
    par_ld = 1'b1; par_m = '1; par_n = '1;
    tick(3); rst_n = 1'b1; tick(4);

    // R1 reset values
    chk("R1 m", int'(m_val), 127);
    chk("R1 n", int'(n_code), 3);
    chk("R1 t", int'(t_sel), 0);
    chk("R1 ser_out", int'(ser_out), 0);

    // serial word with strobe low: settings untouched
    sword(12'b101_10_0110000);
    chk("R2 ser_out first bit", int'(ser_out), 1);
    chk("R5 m before strobe", int'(m_val), 127);
    spulse();
    chk("R3 t field", int'(t_sel), 5);
    chk("R3 n field", int'(n_code), 2);
    chk("R3 m field", int'(m_val), 48);

    // more shifting after strobe fell
    sbit(1'b0); sbit(1'b0); sbit(1'b0);
    chk("R5 hold t", int'(t_sel), 5);
    chk("R5 hold m", int'(m_val), 48);

    // transparency while strobe high: word becomes 0x301 then follows
    ser_ld = 1'b1; tick(1);
    sbit(1'b1);
    chk("R4 follow t", int'(t_sel), 1);
    chk("R4 follow m", int'(m_val), 1);
    ser_ld = 1'b0; tick(1);

    // serial clock held high many cycles shifts once: 0x301 -> 0x603
    ser_din = 1'b1; ser_clk = 1'b1; tick(6); ser_clk = 1'b0; tick(2);
    spulse();
    chk("R2 single shift m", int'(m_val), 3);
    chk("R2 single shift n", int'(n_code), 0);
    chk("R2 single shift t", int'(t_sel), 3);

    // parallel transparency
    par_m = 7'd25; par_n = 2'd1; par_ld = 1'b0; tick(2);
    chk("R6 m", int'(m_val), 25);
    chk("R6 n", int'(n_code), 1);
    chk("R6 t forced", int'(t_sel), 0);
    par_m = 7'd40; tick(1);
    chk("R6 follow m", int'(m_val), 40);

    // parallel capture then pins ignored
    par_ld = 1'b1; tick(1);
    par_m = 7'd99; par_n = 2'd2; tick(3);
    chk("R7 kept m", int'(m_val), 40);
    chk("R7 kept n", int'(n_code), 1);

    // priority: serial strobe high during parallel transparency
    ser_ld = 1'b1; par_ld = 1'b0; par_m = 7'd10; tick(2);
    chk("R8 m", int'(m_val), 10);
    chk("R8 t", int'(t_sel), 0);
    par_ld = 1'b1; tick(2);
    chk("R8 serial resumes m", int'(m_val), 3);
    chk("R8 serial resumes t", int'(t_sel), 3);
    ser_ld = 1'b0; tick(1);

    // second full word
    sword(12'b011_01_1111111);
    spulse();
    chk("R3 word2 t", int'(t_sel), 3);
    chk("R3 word2 n", int'(n_code), 1);
    chk("R3 word2 m", int'(m_val), 127);

    tick(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule